// File: doc/BRIEF.md
# Register Rename Stage with Speculative and Committed Maps

This block renames the register operands of micro-ops in an out-of-order integer core. There are eight architectural registers: four data registers, two index registers, a stack pointer and a base pointer. They are mapped onto a larger, unified pool of physical registers, and each physical register is named by a tag. A speculative map, read and written at rename, translates the source operands of each micro-op. When the micro-op writes a register, the map also gives its destination a fresh tag taken from a pool of unused tags.

A second map holds only committed mappings. Accepted micro-ops wait in an in-order queue of (destination register, tag) records until they retire. Retiring the oldest record moves no data. It rewrites one entry of the committed map and hands the tag that entry used to hold back to the pool. A flush discards everything in flight. The speculative map is reloaded from the committed map in one cycle, and the pool is rebuilt from every tag the committed map does not hold. Register values, wakeup and execution live elsewhere.

Top module: `rename_core`

## Requirements
- R1: After reset, architectural register i maps to tag i in both maps, tags ARCH_REGS to PHYS_REGS-1 are unused, and the in-order queue is empty. Tags are $clog2(PHYS_REGS) bits wide, which is 7 bits for the default pool of 128.
- R2: An accepted micro-op with a destination is given the lowest-numbered unused tag on `ren_dst_tag` in the same cycle. From the next cycle onwards that tag is the speculative mapping of its destination register and is no longer unused.
- R3: `ren_src_a_tag` and `ren_src_b_tag` combinationally show the speculative mapping of the source registers as it stood before this micro-op's own destination update.
- R4: An accepted micro-op without a destination consumes no tag and leaves the speculative map unchanged.
- R5: `ren_ready` is high exactly when `flush` is low, at least one tag is unused, and the in-order queue holds fewer than QUEUE_DEPTH records. A micro-op is accepted only when `ren_valid` and `ren_ready` are both high.
- R6: A retirement happens when `ret_valid` and `ret_ready` are both high. It takes the oldest record. If that record has a destination, then in the same cycle `ret_free_valid` is high and `ret_free_tag` shows the tag the committed map held for that register. The committed map entry then takes the record's tag, and the returned tag can be allocated from the next cycle.
- R7: Retiring a record without a destination keeps `ret_free_valid` low and changes neither map.
- R8: `ret_ready` is high exactly when `flush` is low and the in-order queue is not empty.
- R9: While `flush` is high, nothing is renamed or retired. From the next cycle the speculative map equals the committed map, the queue is empty, and the unused tags are exactly those the committed map does not hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | A micro-op is offered for renaming |
| ren_ready | output | 1 | The stage can accept the offered micro-op |
| ren_has_dst | input | 1 | The micro-op writes a register |
| ren_dst_arch | input | $clog2(ARCH_REGS) | Destination architectural register |
| ren_src_a_arch | input | $clog2(ARCH_REGS) | First source architectural register |
| ren_src_b_arch | input | $clog2(ARCH_REGS) | Second source architectural register |
| ren_dst_tag | output | $clog2(PHYS_REGS) | Tag given to the destination |
| ren_src_a_tag | output | $clog2(PHYS_REGS) | Speculative mapping of the first source |
| ren_src_b_tag | output | $clog2(PHYS_REGS) | Speculative mapping of the second source |
| ret_valid | input | 1 | Request to retire the oldest record |
| ret_ready | output | 1 | A record is available to retire |
| ret_free_valid | output | 1 | A tag is returned to the pool this cycle |
| ret_free_tag | output | $clog2(PHYS_REGS) | The returned tag |
| flush | input | 1 | Discard in-flight work and restore the speculative map |

## Verification
All rename and retire outputs are combinational from the current state and the current inputs. The bench therefore drives each cycle's inputs just after a falling edge and compares the outputs one time step later, in that same cycle. Map, pool and queue updates become visible only through outputs in the following cycle. The bench's reference model applies its update after each comparison, so the next cycle's expected lookups, allocations and returned tags already include it. The effect of a flush is checked on the first cycle after it, through the source lookups and the lowest-tag allocation.

// File: rtl/rename_pkg.sv
package rename_pkg;
  // Index width for a table of n entries, never below one bit.
  function automatic int unsigned idx_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // Width able to hold the count 0..n.
  function automatic int unsigned cnt_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/rn_alias_table.sv
module rn_alias_table #(
  parameter int unsigned NREG = 8,
  parameter int unsigned TW   = 7,
  localparam int unsigned IW  = rename_pkg::idx_width(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IW-1:0]      wr_idx,
  input  logic [TW-1:0]      wr_tag,
  input  logic               restore_en,
  input  logic [NREG*TW-1:0] restore_map,
  output logic [NREG*TW-1:0] map_flat
);
  logic [TW-1:0] map_q [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) map_q[i] <= TW'(i);
    end else if (restore_en) begin
      for (int i = 0; i < NREG; i++) map_q[i] <= restore_map[i*TW +: TW];
    end else if (wr_en) begin
      map_q[wr_idx] <= wr_tag;
    end
  end

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_flat
      assign map_flat[g*TW +: TW] = map_q[g];
    end
  endgenerate

  // R9: a restore leaves the table equal to its source image
  p_restore_copies_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restore_en |=> map_flat == $past(restore_map));
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int unsigned NPHYS = 128,
  parameter int unsigned NARCH = 8,
  parameter int unsigned TW    = 7,
  localparam int unsigned CW   = rename_pkg::cnt_width(NPHYS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                alloc_en,
  output logic [TW-1:0]       alloc_tag,
  output logic                empty,
  input  logic                free_en,
  input  logic [TW-1:0]       free_tag,
  input  logic                rebuild_en,
  input  logic [NARCH*TW-1:0] keep_map,
  output logic [CW-1:0]       free_count
);
  logic [NPHYS-1:0] avail_q, avail_d;

  function automatic logic [TW-1:0] lowest_set(input logic [NPHYS-1:0] v);
    logic [TW-1:0] r;
    r = '0;
    for (int i = NPHYS - 1; i >= 0; i--) if (v[i]) r = TW'(i);
    return r;
  endfunction

  assign alloc_tag  = lowest_set(avail_q);
  assign empty      = (avail_q == '0);
  assign free_count = CW'($countones(avail_q));

  always_comb begin
    avail_d = avail_q;
    if (rebuild_en) begin
      avail_d = '1;
      for (int i = 0; i < NARCH; i++) avail_d[keep_map[i*TW +: TW]] = 1'b0;
    end else begin
      if (alloc_en) avail_d[alloc_tag] = 1'b0;
      if (free_en)  avail_d[free_tag]  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) avail_q[i] <= (i >= NARCH);
    end else begin
      avail_q <= avail_d;
    end
  end

  p_alloc_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !empty);
  p_no_double_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    free_en |-> !avail_q[free_tag]);
  p_alloc_free_distinct_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_en && free_en) |-> alloc_tag != free_tag);
  p_alloc_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_en && !rebuild_en) |=> !avail_q[$past(alloc_tag)]);
endmodule

// File: rtl/rn_order_queue.sv
module rn_order_queue #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned AW    = 3,
  parameter int unsigned TW    = 7,
  localparam int unsigned PW   = rename_pkg::idx_width(DEPTH),
  localparam int unsigned CW   = rename_pkg::cnt_width(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          push_has_dst,
  input  logic [AW-1:0] push_arch,
  input  logic [TW-1:0] push_tag,
  input  logic          pop,
  input  logic          clear,
  output logic          head_has_dst,
  output logic [AW-1:0] head_arch,
  output logic [TW-1:0] head_tag,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] dst_count
);
  logic          hd_q   [DEPTH];
  logic [AW-1:0] arch_q [DEPTH];
  logic [TW-1:0] tag_q  [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty        = (cnt_q == '0);
  assign full         = (cnt_q == CW'(DEPTH));
  assign head_has_dst = hd_q[rd_q];
  assign head_arch    = arch_q[rd_q];
  assign head_tag     = tag_q[rd_q];

  always_ff @(posedge clk) begin
    if (push && !clear) begin
      hd_q[wr_q]   <= push_has_dst;
      arch_q[wr_q] <= push_arch;
      tag_q[wr_q]  <= push_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      rd_q      <= '0;
      wr_q      <= '0;
      cnt_q     <= '0;
      dst_count <= '0;
    end else begin
      if (push) wr_q <= step(wr_q);
      if (pop)  rd_q <= step(rd_q);
      cnt_q     <= cnt_q + CW'(push) - CW'(pop);
      dst_count <= dst_count + CW'(push && push_has_dst) - CW'(pop && head_has_dst);
    end
  end

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> empty);
endmodule

// File: rtl/rename_core.sv
module rename_core #(
  parameter int unsigned ARCH_REGS   = 8,
  parameter int unsigned PHYS_REGS   = 128,
  parameter int unsigned QUEUE_DEPTH = 32,
  localparam int unsigned AW = rename_pkg::idx_width(ARCH_REGS),
  localparam int unsigned TW = rename_pkg::idx_width(PHYS_REGS),
  localparam int unsigned FCW = rename_pkg::cnt_width(PHYS_REGS),
  localparam int unsigned QCW = rename_pkg::cnt_width(QUEUE_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_valid,
  output logic          ren_ready,
  input  logic          ren_has_dst,
  input  logic [AW-1:0] ren_dst_arch,
  input  logic [AW-1:0] ren_src_a_arch,
  input  logic [AW-1:0] ren_src_b_arch,
  output logic [TW-1:0] ren_dst_tag,
  output logic [TW-1:0] ren_src_a_tag,
  output logic [TW-1:0] ren_src_b_tag,
  input  logic          ret_valid,
  output logic          ret_ready,
  output logic          ret_free_valid,
  output logic [TW-1:0] ret_free_tag,
  input  logic          flush
);
  // Named internal events
  logic                    ren_fire, alloc_fire, ret_fire;
  logic                    pool_empty, q_empty, q_full;
  logic [TW-1:0]           pool_tag;
  logic [FCW-1:0]          pool_count;
  logic [QCW-1:0]          inflight_dst;
  logic                    head_has_dst;
  logic [AW-1:0]           head_arch;
  logic [TW-1:0]           head_tag;
  logic [ARCH_REGS*TW-1:0] spec_flat, commit_flat;

  function automatic logic [TW-1:0] lookup(input logic [ARCH_REGS*TW-1:0] m,
                                           input logic [AW-1:0] idx);
    return m[idx*TW +: TW];
  endfunction

  assign ren_ready  = !flush && !pool_empty && !q_full;
  assign ren_fire   = ren_valid && ren_ready;
  assign alloc_fire = ren_fire && ren_has_dst;

  assign ren_dst_tag   = pool_tag;
  assign ren_src_a_tag = lookup(spec_flat, ren_src_a_arch);
  assign ren_src_b_tag = lookup(spec_flat, ren_src_b_arch);

  assign ret_ready      = !flush && !q_empty;
  assign ret_fire       = ret_valid && ret_ready;
  assign ret_free_valid = ret_fire && head_has_dst;
  assign ret_free_tag   = lookup(commit_flat, head_arch);

  rn_alias_table #(.NREG(ARCH_REGS), .TW(TW)) u_spec_map (
    .clk(clk), .rst_n(rst_n),
    .wr_en(alloc_fire), .wr_idx(ren_dst_arch), .wr_tag(pool_tag),
    .restore_en(flush), .restore_map(commit_flat),
    .map_flat(spec_flat)
  );

  rn_alias_table #(.NREG(ARCH_REGS), .TW(TW)) u_commit_map (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ret_free_valid), .wr_idx(head_arch), .wr_tag(head_tag),
    .restore_en(1'b0), .restore_map('0),
    .map_flat(commit_flat)
  );

  rn_free_list #(.NPHYS(PHYS_REGS), .NARCH(ARCH_REGS), .TW(TW)) u_pool (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(alloc_fire), .alloc_tag(pool_tag), .empty(pool_empty),
    .free_en(ret_free_valid), .free_tag(ret_free_tag),
    .rebuild_en(flush), .keep_map(commit_flat),
    .free_count(pool_count)
  );

  rn_order_queue #(.DEPTH(QUEUE_DEPTH), .AW(AW), .TW(TW)) u_order (
    .clk(clk), .rst_n(rst_n),
    .push(ren_fire), .push_has_dst(ren_has_dst), .push_arch(ren_dst_arch),
    .push_tag(pool_tag),
    .pop(ret_fire), .clear(flush),
    .head_has_dst(head_has_dst), .head_arch(head_arch), .head_tag(head_tag),
    .empty(q_empty), .full(q_full), .dst_count(inflight_dst)
  );

  // R2: every tag is mapped in the committed map, held by an in-flight record, or unused
  p_tag_conservation_r2: assert property (@(posedge clk) disable iff (!rst_n || $past(flush))
    (int'(pool_count) + int'(inflight_dst)) == int'(PHYS_REGS - ARCH_REGS));
  p_flush_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !ren_ready && !ret_ready);
  p_no_dst_no_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_fire && !ren_has_dst && !flush) |=> spec_flat == $past(spec_flat));
  p_retire_nodst_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_free_valid && !flush) |=> commit_flat == $past(commit_flat));
endmodule

// File: tb/rename_core_tb_top.sv
module rename_core_tb_top;
  localparam int NA = 8;
  localparam int NP = 16;
  localparam int QD = 12;
  localparam int AW = 3;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ren_valid = 0, ren_has_dst = 0, ret_valid = 0, flush = 0;
  logic [AW-1:0] ren_dst_arch = '0, ren_src_a_arch = '0, ren_src_b_arch = '0;
  logic ren_ready, ret_ready, ret_free_valid;
  logic [TW-1:0] ren_dst_tag, ren_src_a_tag, ren_src_b_tag, ret_free_tag;

  always #5 clk = ~clk;

  rename_core #(.ARCH_REGS(NA), .PHYS_REGS(NP), .QUEUE_DEPTH(QD)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .ren_valid(ren_valid), .ren_ready(ren_ready), .ren_has_dst(ren_has_dst),
    .ren_dst_arch(ren_dst_arch), .ren_src_a_arch(ren_src_a_arch),
    .ren_src_b_arch(ren_src_b_arch), .ren_dst_tag(ren_dst_tag),
    .ren_src_a_tag(ren_src_a_tag), .ren_src_b_tag(ren_src_b_tag),
    .ret_valid(ret_valid), .ret_ready(ret_ready),
    .ret_free_valid(ret_free_valid), .ret_free_tag(ret_free_tag),
    .flush(flush)
  );

  typedef struct { bit hd; int a; int t; } rec_t;
  int   spec_m[NA];
  int   comm_m[NA];
  bit   unused_t[NP];
  rec_t inflight[$];
  int   n_vec = 0, n_bad = 0;
  bit   after_flush = 0, after_nodst = 0;

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int lowest_unused();
    for (int i = 0; i < NP; i++) if (unused_t[i]) return i;
    return -1;
  endfunction

  task automatic one_cycle(input int p_ren, input int p_dst, input int p_ret, input int p_flush);
    int  low;
    bit  exp_rdy, exp_rr, rfire, wfire;
    string sreq;
    @(negedge clk);
    ren_valid      = ($urandom_range(99) < p_ren);
    ren_has_dst    = ($urandom_range(99) < p_dst);
    ren_dst_arch   = AW'($urandom_range(NA - 1));
    ren_src_a_arch = AW'($urandom_range(NA - 1));
    ren_src_b_arch = AW'($urandom_range(NA - 1));
    ret_valid      = ($urandom_range(99) < p_ret);
    flush          = ($urandom_range(999) < p_flush);
    #1;
    low     = lowest_unused();
    exp_rdy = !flush && (low >= 0) && (inflight.size() < QD);
    exp_rr  = !flush && (inflight.size() > 0);
    check("R5 ren_ready", int'(ren_ready), int'(exp_rdy));
    check("R8 ret_ready", int'(ret_ready), int'(exp_rr));
    wfire = ren_valid && exp_rdy;
    rfire = ret_valid && exp_rr;
    if (wfire) begin
      sreq = after_flush ? "R9 lookup after flush" : (after_nodst ? "R4 lookup after no-dst op" : "R3 source lookup");
      check(sreq, int'(ren_src_a_tag), spec_m[ren_src_a_arch]);
      check(sreq, int'(ren_src_b_tag), spec_m[ren_src_b_arch]);
      if (ren_has_dst)
        check(after_flush ? "R9 allocation after flush" : "R2 lowest unused tag", int'(ren_dst_tag), low);
    end
    if (rfire && !inflight[0].hd) check("R7 no return", int'(ret_free_valid), 0);
    else check("R6 return valid", int'(ret_free_valid), int'(rfire));
    if (rfire && inflight[0].hd) check("R6 returned tag", int'(ret_free_tag), comm_m[inflight[0].a]);
    // model update
    after_flush = flush;
    if (wfire) after_nodst = !ren_has_dst;
    if (flush) begin
      inflight.delete();
      for (int i = 0; i < NP; i++) unused_t[i] = 1;
      for (int i = 0; i < NA; i++) begin
        spec_m[i] = comm_m[i];
        unused_t[comm_m[i]] = 0;
      end
    end else begin
      if (wfire) begin
        rec_t r;
        r.hd = ren_has_dst; r.a = int'(ren_dst_arch); r.t = low;
        if (ren_has_dst) begin
          unused_t[low] = 0;
          spec_m[ren_dst_arch] = low;
        end
        inflight.push_back(r);
      end
      if (rfire) begin
        rec_t h;
        h = inflight.pop_front();
        if (h.hd) begin
          unused_t[comm_m[h.a]] = 1;
          comm_m[h.a] = h.t;
        end
      end
    end
  endtask

  initial begin
    #(200000 * 10);
    n_vec++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NA; i++) begin spec_m[i] = i; comm_m[i] = i; end
    for (int i = 0; i < NP; i++) unused_t[i] = (i >= NA);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state seen at the ports
    check("R1 ren_ready after reset", int'(ren_ready), 1);
    check("R1 ret_ready after reset", int'(ret_ready), 0);
    check("R1 first tag after reset", int'(ren_dst_tag), NA);
    for (int i = 0; i < NA; i++) begin
      ren_src_a_arch = AW'(i);
      #1;
      check("R1 identity map", int'(ren_src_a_tag), i);
    end
    // Allocation-heavy: drains the pool and stalls on it
    repeat (400) one_cycle(85, 95, 15, 0);
    // No-destination heavy: fills the queue
    repeat (400) one_cycle(90, 5, 10, 0);
    // Balanced with occasional flushes
    repeat (1500) one_cycle(60, 70, 50, 30);
    // Retire-heavy
    repeat (400) one_cycle(20, 80, 90, 10);
    // Frequent flushes
    repeat (600) one_cycle(70, 80, 60, 150);
    @(negedge clk);
    ren_valid = 0; ret_valid = 0; flush = 0;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule